// File: doc/BRIEF.md
# Debug Component Discovery Crawler

This block walks a debug address space in hardware to find the debug components in it, starting from one base address. It reads 32-bit words through a simple memory port with one read outstanding at a time. For each candidate component it collects the identification bytes from the top of the component's 4 KB window and checks the fixed identifier pattern. It then decides whether the component is a directory table or a leaf.

A directory table is scanned entry by entry. A present entry leads the crawler into a child component. A child that is itself a table is entered by saving the parent's position on a small hardware stack. When the child table ends, the parent resumes at its next entry. A leaf must carry the expected designer code. It is then looked up in a parameterised part list and reported on a valid/ready stream with its address, class nibble, part number, a list-hit flag and a class-mismatch warning. A `done` level marks the end of the walk, and a sticky flag records that a child was dropped because the stack was full.

Top module: `dbg_rom_walker`

## Requirements
- R1: After reset `req_valid`, `rep_valid`, `done` and `stack_err` are all low, and nothing is requested until `start` is seen.
- R2: The component base is `base_addr` with bits [1:0] cleared. Every request address is word aligned. A leaf is reported at that cleared base.
- R3: The 32-bit identifier takes bits [8k+7:8k] from bits [7:0] of the word at offset 0xFF0+4k, for k = 0..3; the upper 24 bits of those words are ignored. A component whose identifier differs from 0xB105000D in any bit outside [15:12] is dropped without a report.
- R4: Identifier bits [15:12] form the class. Class 0x1 is walked as a table. Any other class is treated as a leaf, and its class value appears on `rep_class`.
- R5: Table entry i is read at table base + 4i. The value 0 ends the table. A non-zero value with bit 0 clear is skipped. Otherwise the child base is table base + (entry with bits [11:0] cleared), modulo 2^32. Entries are visited in ascending order.
- R6: A table is scanned for at most MAX_ENTRIES (256) entries, and no entry address at or beyond base + 4*MAX_ENTRIES is read.
- R7: The 40-bit product identifier takes bits [7:0] of the words at offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC as bytes 0 to 3, and bits [7:0] at 0xFD0 as bits [39:32]. A leaf is reported only if the identifier with bits [31:20] and [11:0] cleared equals 0x04000BB000. The revision field [31:20] has no effect.
- R8: `rep_part` is product identifier bits [11:0]. `rep_match` is high when that part is in the part list (default 0x000, 0x008, 0x906). `rep_warn` is high when the matched part has an expected class (0xE for 0x000 and 0x008; none for 0x906) that differs from the read class.
- R9: A read answered with `rsp_fault` high abandons the current component or entry without a report, and the walk goes on with the parent table's next entry.
- R10: At most STACK_DEPTH (4) parent tables can be saved, so five nested tables can be active. A child table beyond that is skipped and `stack_err` is set. The flag stays high until the next accepted `start`.
- R11: A report is presented with `rep_valid` high, and all report fields are held stable until `rep_ready` is high. Exactly one beat is produced per reported leaf.
- R12: `req_valid` and `req_addr` are held until `req_ready`. No new request is made while a response is pending.
- R13: `done` rises when the walk ends and stays high with no requests or reports until the next `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken when idle) |
| base_addr | input | 32 | Address of the first component |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 32 | Word address of the read |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read response data |
| rsp_fault | input | 1 | Read response error |
| rep_valid | output | 1 | Report beat valid |
| rep_ready | input | 1 | Report beat accepted |
| rep_addr | output | 32 | Base of the reported leaf |
| rep_class | output | 4 | Class nibble of the leaf |
| rep_part | output | 12 | Part number of the leaf |
| rep_match | output | 1 | Part found in the part list |
| rep_warn | output | 1 | Expected class differs from read class |
| done | output | 1 | Walk finished |
| stack_err | output | 1 | A child table was dropped for lack of stack |

## Verification
A table of single-leaf cases varies the class nibble, the part number, the revision field, the continuation byte, the preamble byte and the low address bits. These cases separate a reported leaf from a rejected one and a list hit with a warning from a clean hit or a miss. A hand-built hierarchy mixes present, skipped and wrapping entries with a nested table, which shows entry order, child address arithmetic and the parent resuming after the child. Separate walks inject a fault, chain six tables to exhaust the stack, fill a table with 256 skip entries to test the scan limit, and stall both handshakes.

// File: rtl/rw_pkg.sv
package rw_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ID_REQ,
    S_ID_WAIT,
    S_EVAL,
    S_ENT_REQ,
    S_ENT_WAIT,
    S_REPORT,
    S_NEXT,
    S_TEND
  } walk_st_t;

  localparam logic [31:0] CID_PATTERN = 32'hB105_000D;
  localparam logic [39:0] DES_MASK    = 40'hFF_000F_F000;
  localparam logic [39:0] DES_VALUE   = 40'h04_000B_B000;
  localparam logic [3:0]  CLS_TABLE   = 4'h1;
  localparam logic [3:0]  ID_LAST     = 4'd8;

  // Read order: product bytes 0..3, product byte 4, identifier bytes 0..3
  function automatic logic [11:0] id_offset(input logic [3:0] idx);
    case (idx)
      4'd0:    id_offset = 12'hFE0;
      4'd1:    id_offset = 12'hFE4;
      4'd2:    id_offset = 12'hFE8;
      4'd3:    id_offset = 12'hFEC;
      4'd4:    id_offset = 12'hFD0;
      4'd5:    id_offset = 12'hFF0;
      4'd6:    id_offset = 12'hFF4;
      4'd7:    id_offset = 12'hFF8;
      default: id_offset = 12'hFFC;
    endcase
  endfunction

endpackage

// File: rtl/rw_part_match.sv
module rw_part_match #(
  parameter int                     NPARTS  = 3,
  parameter logic [NPARTS*12-1:0]   PARTS   = '0,
  parameter logic [NPARTS*4-1:0]    CLASSES = '0,
  parameter logic [NPARTS-1:0]      CHECKED = '0
) (
  input  logic [11:0] part,
  input  logic [3:0]  cls,
  output logic        hit,
  output logic        warn
);

  logic [NPARTS-1:0] eq;
  logic [NPARTS-1:0] mism;

  for (genvar g = 0; g < NPARTS; g++) begin : g_ent
    assign eq[g]   = (part == PARTS[g*12 +: 12]);
    assign mism[g] = eq[g] & CHECKED[g] & (cls != CLASSES[g*4 +: 4]);
  end

  assign hit  = |eq;
  assign warn = |mism;

endmodule

// File: rtl/rw_addr_stack.sv
module rw_addr_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int PW = $clog2(DEPTH + 1);

  logic [PW-1:0] ptr_q, ptr_d;
  logic [W-1:0]  slot_q [DEPTH];
  logic          do_push, do_pop;

  assign empty   = (ptr_q == '0);
  assign full    = (ptr_q == PW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    ptr_d = ptr_q;
    if (do_push)     ptr_d = ptr_q + 1'b1;
    else if (do_pop) ptr_d = ptr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               slot_q[g] <= '0;
      else if (do_push && ptr_q == PW'(g))      slot_q[g] <= din;
    end
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ptr_q == PW'(i + 1)) dout = slot_q[i];
  end

endmodule

// File: rtl/dbg_rom_walker.sv
module dbg_rom_walker
  import rw_pkg::*;
#(
  parameter int                   STACK_DEPTH = 4,
  parameter int                   MAX_ENTRIES = 256,
  parameter int                   NPARTS      = 3,
  parameter logic [NPARTS*12-1:0] PART_LIST   = {12'h906, 12'h008, 12'h000},
  parameter logic [NPARTS*4-1:0]  PART_CLASS  = {4'h0, 4'hE, 4'hE},
  parameter logic [NPARTS-1:0]    PART_CHECK  = 3'b011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] base_addr,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_addr,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_data,
  input  logic        rsp_fault,
  output logic        rep_valid,
  input  logic        rep_ready,
  output logic [31:0] rep_addr,
  output logic [3:0]  rep_class,
  output logic [11:0] rep_part,
  output logic        rep_match,
  output logic        rep_warn,
  output logic        done,
  output logic        stack_err
);

  localparam int IW = $clog2(MAX_ENTRIES);
  localparam int SW = 32 + IW;
  localparam logic [IW-1:0] ENT_LAST = IW'(MAX_ENTRIES - 1);

  walk_st_t       st_q, st_d;
  logic [31:0]    cur_q, cur_d;
  logic [31:0]    tbl_q, tbl_d;
  logic [IW-1:0]  ent_q, ent_d;
  logic [3:0]     rd_q, rd_d;
  logic [39:0]    pid_q, pid_d;
  logic [31:0]    cid_q, cid_d;
  logic           act_q, act_d;
  logic           done_q, done_d;
  logic           err_q, err_d;

  logic           push, pop, stk_empty, stk_full;
  logic [SW-1:0]  stk_top;
  logic           hit, warn;
  logic           cid_ok, des_ok;
  logic [3:0]     cls;

  assign cls    = cid_q[15:12];
  assign cid_ok = ({cid_q[31:16], 4'h0, cid_q[11:0]} == CID_PATTERN);
  assign des_ok = ((pid_q & DES_MASK) == DES_VALUE);

  rw_part_match #(
    .NPARTS (NPARTS),
    .PARTS  (PART_LIST),
    .CLASSES(PART_CLASS),
    .CHECKED(PART_CHECK)
  ) u_match (
    .part(pid_q[11:0]),
    .cls (cls),
    .hit (hit),
    .warn(warn)
  );

  rw_addr_stack #(
    .DEPTH(STACK_DEPTH),
    .W    (SW)
  ) u_stack (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push),
    .pop  (pop),
    .din  ({tbl_q, ent_q}),
    .dout (stk_top),
    .empty(stk_empty),
    .full (stk_full)
  );

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    tbl_d  = tbl_q;
    ent_d  = ent_q;
    rd_d   = rd_q;
    pid_d  = pid_q;
    cid_d  = cid_q;
    act_d  = act_q;
    done_d = done_q;
    err_d  = err_q;
    push   = 1'b0;
    pop    = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;

    case (st_q)
      S_IDLE: begin
        if (start) begin
          cur_d  = {base_addr[31:2], 2'b00};
          act_d  = 1'b0;
          err_d  = 1'b0;
          done_d = 1'b0;
          rd_d   = '0;
          pid_d  = '0;
          cid_d  = '0;
          st_d   = S_ID_REQ;
        end
      end

      S_ID_REQ: begin
        req_valid = 1'b1;
        req_addr  = cur_q + {20'h0, id_offset(rd_q)};
        if (req_ready) st_d = S_ID_WAIT;
      end

      S_ID_WAIT: begin
        if (rsp_valid) begin
          if (rsp_fault) begin
            st_d = S_NEXT;
          end else begin
            case (rd_q)
              4'd0:    pid_d[7:0]   = rsp_data[7:0];
              4'd1:    pid_d[15:8]  = rsp_data[7:0];
              4'd2:    pid_d[23:16] = rsp_data[7:0];
              4'd3:    pid_d[31:24] = rsp_data[7:0];
              4'd4:    pid_d[39:32] = rsp_data[7:0];
              4'd5:    cid_d[7:0]   = rsp_data[7:0];
              4'd6:    cid_d[15:8]  = rsp_data[7:0];
              4'd7:    cid_d[23:16] = rsp_data[7:0];
              default: cid_d[31:24] = rsp_data[7:0];
            endcase
            if (rd_q == ID_LAST) begin
              st_d = S_EVAL;
            end else begin
              rd_d = rd_q + 1'b1;
              st_d = S_ID_REQ;
            end
          end
        end
      end

      S_EVAL: begin
        if (!cid_ok) begin
          st_d = S_NEXT;
        end else if (cls == CLS_TABLE) begin
          if (!act_q) begin
            act_d = 1'b1;
            tbl_d = cur_q;
            ent_d = '0;
            st_d  = S_ENT_REQ;
          end else if (stk_full) begin
            err_d = 1'b1;
            st_d  = S_NEXT;
          end else begin
            push  = 1'b1;
            tbl_d = cur_q;
            ent_d = '0;
            st_d  = S_ENT_REQ;
          end
        end else if (des_ok) begin
          st_d = S_REPORT;
        end else begin
          st_d = S_NEXT;
        end
      end

      S_REPORT: begin
        if (rep_ready) st_d = S_NEXT;
      end

      S_NEXT: begin
        if (!act_q) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else if (ent_q == ENT_LAST) begin
          st_d = S_TEND;
        end else begin
          ent_d = ent_q + 1'b1;
          st_d  = S_ENT_REQ;
        end
      end

      S_ENT_REQ: begin
        req_valid = 1'b1;
        req_addr  = tbl_q + {{(30-IW){1'b0}}, ent_q, 2'b00};
        if (req_ready) st_d = S_ENT_WAIT;
      end

      S_ENT_WAIT: begin
        if (rsp_valid) begin
          if (rsp_fault || (rsp_data != '0 && !rsp_data[0])) begin
            st_d = S_NEXT;
          end else if (rsp_data == '0) begin
            st_d = S_TEND;
          end else begin
            cur_d = tbl_q + {rsp_data[31:12], 12'h000};
            rd_d  = '0;
            pid_d = '0;
            cid_d = '0;
            st_d  = S_ID_REQ;
          end
        end
      end

      S_TEND: begin
        if (stk_empty) begin
          act_d = 1'b0;
        end else begin
          pop   = 1'b1;
          tbl_d = stk_top[SW-1:IW];
          ent_d = stk_top[IW-1:0];
        end
        st_d = S_NEXT;
      end

      default: st_d = S_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      tbl_q  <= '0;
      ent_q  <= '0;
      rd_q   <= '0;
      pid_q  <= '0;
      cid_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      tbl_q  <= tbl_d;
      ent_q  <= ent_d;
      rd_q   <= rd_d;
      pid_q  <= pid_d;
      cid_q  <= cid_d;
      act_q  <= act_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign rep_valid = (st_q == S_REPORT);
  assign rep_addr  = cur_q;
  assign rep_class = cls;
  assign rep_part  = pid_q[11:0];
  assign rep_match = hit;
  assign rep_warn  = warn;
  assign done      = done_q;
  assign stack_err = err_q;

endmodule

// File: rtl/rw_walker_chk.sv
module rw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rep_valid,
  input logic        rep_ready,
  input logic [31:0] rep_addr,
  input logic [3:0]  rep_class,
  input logic [11:0] rep_part,
  input logic        rep_match,
  input logic        rep_warn,
  input logic        done,
  input logic        stack_err
);

  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pending_q <= 1'b0;
    else if (req_valid && req_ready) pending_q <= 1'b1;
    else if (rsp_valid)              pending_q <= 1'b0;
  end

  // R2: every request is word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[1:0] == 2'b00));

  // R11: report beat held until accepted
  a_r11_rep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_addr) &&
      $stable(rep_class) && $stable(rep_part) && $stable(rep_match) &&
      $stable(rep_warn)));

  // R12: request held until accepted
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R12: single outstanding read
  a_r12_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> !req_valid);

  // R13: quiet once finished
  a_r13_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!req_valid && !rep_valid));

  // R10: error flag is sticky until a start
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_err && !start) |=> stack_err);

endmodule

bind dbg_rom_walker rw_walker_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rep_valid(rep_valid),
  .rep_ready(rep_ready),
  .rep_addr (rep_addr),
  .rep_class(rep_class),
  .rep_part (rep_part),
  .rep_match(rep_match),
  .rep_warn (rep_warn),
  .done     (done),
  .stack_err(stack_err)
);

// File: tb/dbg_rom_walker_test.sv
module dbg_rom_walker_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int MEM_N      = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [31:0] req_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        rsp_fault = 1'b0;
  logic        rep_valid;
  logic        rep_ready = 1'b1;
  logic [31:0] rep_addr;
  logic [3:0]  rep_class;
  logic [11:0] rep_part;
  logic        rep_match, rep_warn, done, stack_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_rom_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_addr(rep_addr),
    .rep_class(rep_class), .rep_part(rep_part), .rep_match(rep_match),
    .rep_warn(rep_warn), .done(done), .stack_err(stack_err)
  );

  // ---------------- memory model ----------------
  logic [31:0] m_addr [MEM_N];
  logic [31:0] m_data [MEM_N];
  int          m_n = 0;
  logic        fault_en = 1'b0;
  logic [31:0] fault_addr = '0;
  logic        fill_en = 1'b0;
  logic [31:0] win_base = '0;
  int          cnt_in = 0, cnt_out = 0;
  logic        toggle_rdy = 1'b0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    logic [31:0] v;
    v = '0;
    if (fill_en && a >= win_base && a < win_base + 32'h400) v = 32'h2;
    for (int i = 0; i < MEM_N; i++)
      if (i < m_n && m_addr[i] == a) v = m_data[i];
    return v;
  endfunction

  always @(posedge clk) begin
    rsp_valid <= req_valid && req_ready;
    if (req_valid && req_ready) begin
      rsp_data  <= mem_rd(req_addr);
      rsp_fault <= fault_en && (req_addr == fault_addr);
      if (req_addr >= win_base && req_addr < win_base + 32'h400) cnt_in <= cnt_in + 1;
      if (req_addr == win_base + 32'h400) cnt_out <= cnt_out + 1;
    end else begin
      rsp_fault <= 1'b0;
    end
  end

  always @(negedge clk) req_ready <= toggle_rdy ? !req_ready : 1'b1;

  // ---------------- report capture ----------------
  int          rcount = 0;
  logic [31:0] r_addr  [8];
  logic [3:0]  r_class [8];
  logic [11:0] r_part  [8];
  logic        r_match [8];
  logic        r_warn  [8];

  always @(posedge clk) begin
    if (rep_valid && rep_ready) begin
      if (rcount < 8) begin
        r_addr[rcount]  <= rep_addr;
        r_class[rcount] <= rep_class;
        r_part[rcount]  <= rep_part;
        r_match[rcount] <= rep_match;
        r_warn[rcount]  <= rep_warn;
      end
      rcount <= rcount + 1;
    end
  end

  // ---------------- checking ----------------
  int errs = 0, checks = 0;

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    m_addr[m_n] = a;
    m_data[m_n] = d;
    m_n++;
  endtask

  task automatic clear_mem();
    m_n = 0;
    fault_en = 1'b0;
    fill_en = 1'b0;
    win_base = 32'hF000_0000;
  endtask

  // Component identification block; upper bits of every word carry junk.
  task automatic put_comp(input logic [31:0] b, input logic [3:0] cls,
                          input logic [39:0] pid, input logic bad);
    put(b + 32'hFE0, 32'hA5C3_E100 | {24'h0, pid[7:0]});
    put(b + 32'hFE4, 32'h5A3C_1E00 | {24'h0, pid[15:8]});
    put(b + 32'hFE8, 32'hFFFF_FF00 | {24'h0, pid[23:16]});
    put(b + 32'hFEC, 32'h1234_5600 | {24'h0, pid[31:24]});
    put(b + 32'hFD0, 32'h8765_4300 | {24'h0, pid[39:32]});
    put(b + 32'hFF0, 32'hCAFE_0000 | (bad ? 32'h0C : 32'h0D));
    put(b + 32'hFF4, 32'hBEEF_0000 | {24'h0, cls, 4'h0});
    put(b + 32'hFF8, 32'h7777_7700 | 32'h05);
    put(b + 32'hFFC, 32'h0101_0100 | 32'hB1);
  endtask

  task automatic run_walk(input logic [31:0] b);
    @(negedge clk);
    rcount = 0;
    base_addr = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < 20000 && !done; g++) @(negedge clk);
    chk(done, "R13 walk finished", {63'h0, done}, 64'h1);
  endtask

  typedef struct packed {
    logic [31:0] base;
    logic [3:0]  cls;
    logic [39:0] pid;
    logic        bad;
    logic        exp_rep;
    logic        exp_match;
    logic        exp_warn;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{32'h1000_0000, 4'h9, 40'h04_000B_B000, 1'b0, 1'b1, 1'b1, 1'b1},
    '{32'h1000_0000, 4'hE, 40'h04_000B_B008, 1'b0, 1'b1, 1'b1, 1'b0},
    '{32'h1000_0000, 4'h9, 40'h04_000B_B906, 1'b0, 1'b1, 1'b1, 1'b0},
    '{32'h1000_0000, 4'h9, 40'h04_000B_B123, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h1000_0000, 4'h9, 40'h04_000A_B123, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1000_0000, 4'hE, 40'h04_000B_B008, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h1000_0000, 4'hE, 40'h04_123B_B008, 1'b0, 1'b1, 1'b1, 1'b0},
    '{32'h1000_0003, 4'h9, 40'h04_000B_B906, 1'b0, 1'b1, 1'b1, 1'b0},
    '{32'h1000_0000, 4'hE, 40'h05_000B_B000, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!req_valid && !rep_valid && !done && !stack_err, "R1 reset outputs",
        {60'h0, req_valid, rep_valid, done, stack_err}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!req_valid, "R1 idle without start", {63'h0, req_valid}, 64'h0);

    // Vector table: single leaf at the base (R2 R3 R4 R7 R8)
    for (int v = 0; v < 9; v++) begin
      clear_mem();
      put_comp({VEC[v].base[31:2], 2'b00}, VEC[v].cls, VEC[v].pid, VEC[v].bad);
      run_walk(VEC[v].base);
      chk(rcount == (VEC[v].exp_rep ? 1 : 0), "R3 R7 report count",
          64'(rcount), {63'h0, VEC[v].exp_rep});
      if (VEC[v].exp_rep && rcount == 1) begin
        chk(r_addr[0] == {VEC[v].base[31:2], 2'b00}, "R2 report address",
            {32'h0, r_addr[0]}, {32'h0, VEC[v].base[31:2], 2'b00});
        chk(r_class[0] == VEC[v].cls, "R4 leaf class",
            {60'h0, r_class[0]}, {60'h0, VEC[v].cls});
        chk(r_part[0] == VEC[v].pid[11:0], "R8 part number",
            {52'h0, r_part[0]}, {52'h0, VEC[v].pid[11:0]});
        chk(r_match[0] == VEC[v].exp_match, "R8 match flag",
            {63'h0, r_match[0]}, {63'h0, VEC[v].exp_match});
        chk(r_warn[0] == VEC[v].exp_warn, "R8 warn flag",
            {63'h0, r_warn[0]}, {63'h0, VEC[v].exp_warn});
      end
    end

    // Hierarchy: present, skipped, nested and wrapping entries (R5), stalled port (R12)
    clear_mem();
    put_comp(32'h2000_0000, 4'h1, 40'h0, 1'b0);
    put(32'h2000_0000, 32'h0001_0FF3);
    put(32'h2000_0004, 32'h0002_0002);
    put(32'h2000_0008, 32'h0003_0001);
    put(32'h2000_000C, 32'hFFFF_0001);
    put(32'h2000_0014, 32'h0005_0001);
    put_comp(32'h2001_0000, 4'hE, 40'h04_000B_B008, 1'b0);
    put_comp(32'h2002_0000, 4'h9, 40'h04_000B_B000, 1'b0);
    put_comp(32'h2003_0000, 4'h1, 40'h0, 1'b0);
    put(32'h2003_0000, 32'h0000_1001);
    put_comp(32'h2003_1000, 4'h9, 40'h04_000B_B906, 1'b0);
    put_comp(32'h1FFF_0000, 4'h9, 40'h04_000B_B123, 1'b0);
    put_comp(32'h2005_0000, 4'h9, 40'h04_000B_B000, 1'b0);
    toggle_rdy = 1'b1;
    run_walk(32'h2000_0000);
    toggle_rdy = 1'b0;
    chk(rcount == 3, "R5 hierarchy report count", 64'(rcount), 64'd3);
    chk(r_addr[0] == 32'h2001_0000, "R5 first child", {32'h0, r_addr[0]}, 64'h2001_0000);
    chk(r_addr[1] == 32'h2003_1000, "R5 nested child", {32'h0, r_addr[1]}, 64'h2003_1000);
    chk(r_addr[2] == 32'h1FFF_0000, "R5 wrapped child", {32'h0, r_addr[2]}, 64'h1FFF_0000);
    chk(!stack_err, "R10 no overflow in shallow walk", {63'h0, stack_err}, 64'h0);

    // Fault on a child's identification read (R9)
    clear_mem();
    put_comp(32'h3000_0000, 4'h1, 40'h0, 1'b0);
    put(32'h3000_0000, 32'h0001_0001);
    put(32'h3000_0004, 32'h0002_0001);
    put_comp(32'h3001_0000, 4'hE, 40'h04_000B_B008, 1'b0);
    put_comp(32'h3002_0000, 4'hE, 40'h04_000B_B000, 1'b0);
    fault_en = 1'b1;
    fault_addr = 32'h3001_0FE8;
    run_walk(32'h3000_0000);
    chk(rcount == 1, "R9 faulted child dropped", 64'(rcount), 64'd1);
    chk(r_addr[0] == 32'h3002_0000, "R9 walk continues", {32'h0, r_addr[0]}, 64'h3002_0000);

    // Six nested tables: the sixth does not fit (R10)
    clear_mem();
    for (int k = 0; k < 6; k++) begin
      put_comp(32'h4000_0000 + 32'(k) * 32'h0100_0000, 4'h1, 40'h0, 1'b0);
      put(32'h4000_0000 + 32'(k) * 32'h0100_0000, 32'h0100_0001);
    end
    put(32'h4500_0000, 32'h0300_0001);
    put(32'h4400_0004, 32'h0200_0001);
    put_comp(32'h4600_0000, 4'h9, 40'h04_000B_B123, 1'b0);
    put_comp(32'h4800_0000, 4'h9, 40'h04_000B_B123, 1'b0);
    run_walk(32'h4000_0000);
    chk(stack_err, "R10 overflow flagged", {63'h0, stack_err}, 64'h1);
    chk(rcount == 1, "R10 overflowed child skipped", 64'(rcount), 64'd1);
    chk(r_addr[0] == 32'h4600_0000, "R10 deepest table resumed", {32'h0, r_addr[0]}, 64'h4600_0000);
    clear_mem();
    put_comp(32'h1000_0000, 4'h9, 40'h04_000B_B123, 1'b0);
    run_walk(32'h1000_0000);
    chk(!stack_err, "R10 flag cleared by start", {63'h0, stack_err}, 64'h0);

    // 256 skip entries: scan limit (R6)
    clear_mem();
    put_comp(32'h6000_0000, 4'h1, 40'h0, 1'b0);
    fill_en = 1'b1;
    win_base = 32'h6000_0000;
    @(negedge clk);
    cnt_in = 0;
    cnt_out = 0;
    run_walk(32'h6000_0000);
    chk(cnt_in == 256, "R6 entries read", 64'(cnt_in), 64'd256);
    chk(cnt_out == 0, "R6 no read past limit", 64'(cnt_out), 64'd0);
    chk(rcount == 0, "R6 no reports", 64'(rcount), 64'd0);

    // Report back-pressure (R11) and quiet after done (R13)
    clear_mem();
    put_comp(32'h5000_0000, 4'hE, 40'h04_000B_B000, 1'b0);
    rep_ready = 1'b0;
    @(negedge clk);
    rcount = 0;
    base_addr = 32'h5000_0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < 200 && !rep_valid; g++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(rep_valid, "R11 valid held while stalled", {63'h0, rep_valid}, 64'h1);
    chk(rep_addr == 32'h5000_0000, "R11 address held", {32'h0, rep_addr}, 64'h5000_0000);
    chk(rcount == 0, "R11 no beat while stalled", 64'(rcount), 64'd0);
    rep_ready = 1'b1;
    for (int g = 0; g < 200 && !done; g++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rcount == 1, "R11 exactly one beat", 64'(rcount), 64'd1);
    chk(done && !req_valid, "R13 done stays quiet", {62'h0, done, req_valid}, 64'h2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule